// File: doc/BRIEF.md
# Self-Synchronising Pseudo-Random IQ Pattern Checker

This block verifies a stream of test samples on a four-lane receive interface. Each lane is twelve bits wide. The sender fills the lanes from two free-running 15-bit maximal-length shift registers, one per channel. The checker holds a reference shift register for each channel. It seeds these references from the words it receives, so it needs no knowledge of the sender's start phase. It locks once the prediction holds for a run of samples, and from then on counts the samples that disagree with the prediction.

A delay-sweep routine outside the block uses it to judge each capture setting. The routine clears the checker, streams samples, and then reads three things: the lock flag, the error count and the count of checked samples. A sticky flag reports any sample in which a quadrature lane is not the bitwise complement of its in-phase lane.

Top module: `pat_lfsr_checker`

## Requirements
- R1: Each reference is a 15-bit register `s`. One step gives `{s[13:0], s[14]^s[13]}`, which is the polynomial x^15 + x^14 + 1 with period 32767. Channel A compares its in-phase lane with `s[11:0]` and its quadrature lane with `~s[11:0]`.
- R2: Channel B has its own reference, separate from channel A. It compares its in-phase lane with `s[14:3]` and its quadrature lane with `~s[14:3]`. A corrupted B sample is counted as an error just like a corrupted A sample.
- R3: The checker seeds both references from three earlier valid words plus the current one. The stream may start at any phase. After seeding, the lock flag rises after 16 consecutive valid samples in which all four lanes match. A mismatch before the 16th match re-seeds the reference and restarts the run. From reset with a clean stream, the lock flag goes high after the 20th valid sample.
- R4: While locked, 8 consecutive valid samples with any mismatch drop the lock flag, and a new search begins. Every mismatch in that run is still counted as an error.
- R5: The error counter adds one for each valid sample, taken while locked, in which any of the four lanes mismatches. It does not count while unlocked.
- R6: Both counters saturate at all-ones and never wrap.
- R7: The checked-sample counter adds one for each valid sample taken while locked.
- R8: Cycles with the valid strobe low are ignored, whatever their lane values. The references advance only on valid samples.
- R9: A clear request zeroes both counters, drops the lock, clears the inversion flag and discards the seeding history.
- R10: A valid sample taken while locked in which a quadrature lane differs from the complement of its in-phase lane sets a sticky inversion flag. The flag stays set until clear or reset.
- R11: After reset, the lock flag, both counters and the inversion flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Clear counters and restart the lock search |
| vld_i | input | 1 | Lane words are a valid sample |
| ai_i | input | 12 | Channel A in-phase lane |
| aq_i | input | 12 | Channel A quadrature lane |
| bi_i | input | 12 | Channel B in-phase lane |
| bq_i | input | 12 | Channel B quadrature lane |
| locked_o | output | 1 | References are locked to the stream |
| err_cnt_o | output | CNT_W | Saturating count of mismatching samples |
| chk_cnt_o | output | CNT_W | Saturating count of checked samples |
| inv_err_o | output | 1 | Sticky quadrature-inversion fault |

## Verification
Suppose a reference steps on the wrong cycle or is seeded from the wrong bits. Every later locked sample then mismatches, so the error count climbs on the next valid sample. Lock is lost eight valid samples later. A wrong lock-run counter moves the rising edge of the lock flag away from the 20th clean sample, and the checked-sample count shifts with it. The bench checks that count exactly after each stimulus group. Saturation and stickiness faults show up as a count that wraps or a flag that falls without a clear.

// File: rtl/pat_lfsr_pkg.sv
// Package: shared types, constants and step function of the 15-bit
// x^15 + x^14 + 1 test-pattern shift register.
// Assumes: state bit 0 holds the newest bit; lanes are 12 bits wide.
package pat_lfsr_pkg;
    localparam int LFSR_W = 15;
    localparam int WORD_W = 12;
    localparam int HIST_D = LFSR_W - WORD_W;   // bits hidden from one word

    typedef logic [LFSR_W-1:0] lfsr_t;
    typedef logic [WORD_W-1:0] word_t;

    localparam lfsr_t NOMINAL_SEED = 15'b100000000000001;

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } lock_st_e;

    function automatic lfsr_t lfsr_step(input lfsr_t s);
        return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_W-2]};
    endfunction
endpackage

// File: rtl/pat_ref_chan.sv
// Reference shift register for one channel.
// It keeps the last HIST_D valid in-phase words and builds a full 15-bit
// state estimate from them. It then advances its reference once per valid
// sample, either from that estimate (seed) or from its own state.
// HIGH_VIEW picks which 12 bits of the state the lane carries:
// 0 = low bits, 1 = high bits.
// Assumes: seed_i is only raised on a valid sample with hist_ok_o set.
module pat_ref_chan
    import pat_lfsr_pkg::*;
#(
    parameter bit HIGH_VIEW = 1'b0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr_i,
    input  logic  vld_i,
    input  word_t word_i,
    input  logic  seed_i,
    output word_t pred_o,
    output logic  hist_ok_o
);
    localparam int HCNT_W = $clog2(HIST_D + 1);

    word_t              hist_q [HIST_D];
    logic [HCNT_W-1:0]  hcnt_q;
    lfsr_t              ref_q;
    lfsr_t              cand;

    // Shift the history of received in-phase words on each valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            hcnt_q <= '0;
            for (int k = 0; k < HIST_D; k++) hist_q[k] <= '0;
        end else if (vld_i) begin
            hist_q[0] <= word_i;
            for (int k = 1; k < HIST_D; k++) hist_q[k] <= hist_q[k-1];
            if (hcnt_q != HCNT_W'(HIST_D)) hcnt_q <= hcnt_q + 1'b1;
        end
    end

    assign hist_ok_o = (hcnt_q == HCNT_W'(HIST_D));

    // Rebuild the current state from the oldest history word and this word.
    generate
        if (HIGH_VIEW) begin : g_high
            always_comb begin
                cand = {hist_q[HIST_D-1], word_i[HIST_D-1:0]};
                for (int k = 0; k < HIST_D; k++) cand = lfsr_step(cand);
            end
            assign pred_o = ref_q[LFSR_W-1 -: WORD_W];
        end else begin : g_low
            assign cand   = {hist_q[HIST_D-1][WORD_W-1 -: HIST_D], word_i};
            assign pred_o = ref_q[WORD_W-1:0];
        end
    endgenerate

    // Advance the reference once per valid sample, from the seed or itself.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= NOMINAL_SEED;
        end else if (vld_i) begin
            ref_q <= seed_i ? lfsr_step(cand) : lfsr_step(ref_q);
        end
    end

    p_ref_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> $stable(ref_q));
endmodule

// File: rtl/pat_lock_fsm.sv
// Lock search state machine shared by both channels.
// SEARCH waits for a full seeding history. VERIFY needs LOCK_RUN
// consecutive matches and re-seeds on any miss. LOCKED falls back to
// SEARCH after DROP_RUN consecutive misses.
// Assumes: match_i covers all four lanes of the current sample.
module pat_lock_fsm
    import pat_lfsr_pkg::*;
#(
    parameter int LOCK_RUN = 16,
    parameter int DROP_RUN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic vld_i,
    input  logic hist_ok_i,
    input  logic match_i,
    output logic seed_o,
    output logic locked_o
);
    localparam int RUN_W  = $clog2(LOCK_RUN + 1);
    localparam int DROP_W = $clog2(DROP_RUN + 1);

    lock_st_e           st_q;
    logic [RUN_W-1:0]   run_q;
    logic [DROP_W-1:0]  miss_q;

    // Load the references when searching, or after a miss during verify.
    always_comb begin
        seed_o = 1'b0;
        if (vld_i && hist_ok_i) begin
            if (st_q == ST_SEARCH) seed_o = 1'b1;
            else if (st_q == ST_VERIFY && !match_i) seed_o = 1'b1;
        end
    end

    assign locked_o = (st_q == ST_LOCKED);

    // State and run counters, advanced only on valid samples.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            st_q   <= ST_SEARCH;
            run_q  <= '0;
            miss_q <= '0;
        end else if (vld_i) begin
            case (st_q)
                ST_SEARCH: begin
                    if (hist_ok_i) begin
                        st_q  <= ST_VERIFY;
                        run_q <= '0;
                    end
                end
                ST_VERIFY: begin
                    if (!match_i) begin
                        run_q <= '0;
                    end else if (run_q == RUN_W'(LOCK_RUN - 1)) begin
                        st_q   <= ST_LOCKED;
                        miss_q <= '0;
                    end else begin
                        run_q <= run_q + 1'b1;
                    end
                end
                ST_LOCKED: begin
                    if (match_i) begin
                        miss_q <= '0;
                    end else if (miss_q == DROP_W'(DROP_RUN - 1)) begin
                        st_q <= ST_SEARCH;
                    end else begin
                        miss_q <= miss_q + 1'b1;
                    end
                end
                default: st_q <= ST_SEARCH;
            endcase
        end
    end

    p_verify_miss_no_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_VERIFY && vld_i && !match_i) |=> !locked_o);

    p_lock_from_verify_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> ($past(st_q) == ST_VERIFY && $past(vld_i) && $past(match_i)));

    p_drop_needs_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked_o) |-> ($past(clr_i) || ($past(vld_i) && !$past(match_i))));
endmodule

// File: rtl/pat_sat_counter.sv
// Saturating up-counter: adds one per inc_i, holds at all-ones,
// and zeroes on clr_i.
// Assumes: clr_i takes priority over inc_i.
module pat_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_q;

    // Count up, stopping at full scale.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)           cnt_q <= '0;
        else if (inc_i && ~&cnt_q)     cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    p_sat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (&cnt_q && !clr_i) |=> &cnt_q);

    p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> cnt_q >= $past(cnt_q));
endmodule

// File: rtl/pat_lfsr_checker.sv
// Top level: a four-lane pseudo-random IQ pattern checker.
// It uses two channel references (A low view, B high view), one shared
// lock machine, saturating error and checked-sample counters, and a
// sticky quadrature-inversion flag.
// Assumes: lanes are sampled in the clk domain, qualified by vld_i.
module pat_lfsr_checker
    import pat_lfsr_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int LOCK_RUN = 16,
    parameter int DROP_RUN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             vld_i,
    input  logic [11:0]      ai_i,
    input  logic [11:0]      aq_i,
    input  logic [11:0]      bi_i,
    input  logic [11:0]      bq_i,
    output logic             locked_o,
    output logic [CNT_W-1:0] err_cnt_o,
    output logic [CNT_W-1:0] chk_cnt_o,
    output logic             inv_err_o
);
    word_t pred_a, pred_b;
    logic  hist_ok_a, hist_ok_b;
    logic  seed;
    logic  match;
    logic  inv_bad;
    logic  inv_q;

    pat_ref_chan #(.HIGH_VIEW(1'b0)) u_ref_a (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .vld_i(vld_i),
        .word_i(ai_i), .seed_i(seed), .pred_o(pred_a), .hist_ok_o(hist_ok_a)
    );

    pat_ref_chan #(.HIGH_VIEW(1'b1)) u_ref_b (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .vld_i(vld_i),
        .word_i(bi_i), .seed_i(seed), .pred_o(pred_b), .hist_ok_o(hist_ok_b)
    );

    // Compare all four lanes with the predicted words and their complements.
    always_comb begin
        match   = (ai_i == pred_a) && (aq_i == ~pred_a) &&
                  (bi_i == pred_b) && (bq_i == ~pred_b);
        inv_bad = (aq_i != ~ai_i) || (bq_i != ~bi_i);
    end

    pat_lock_fsm #(.LOCK_RUN(LOCK_RUN), .DROP_RUN(DROP_RUN)) u_lock (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .vld_i(vld_i),
        .hist_ok_i(hist_ok_a && hist_ok_b), .match_i(match),
        .seed_o(seed), .locked_o(locked_o)
    );

    pat_sat_counter #(.W(CNT_W)) u_err_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
        .inc_i(vld_i && locked_o && !match), .cnt_o(err_cnt_o)
    );

    pat_sat_counter #(.W(CNT_W)) u_chk_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
        .inc_i(vld_i && locked_o), .cnt_o(chk_cnt_o)
    );

    // Sticky flag for a quadrature lane that is not the inverse of its partner.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)                     inv_q <= 1'b0;
        else if (vld_i && locked_o && inv_bad)   inv_q <= 1'b1;
    end

    assign inv_err_o = inv_q;

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!locked_o && err_cnt_o == '0 && chk_cnt_o == '0 && !inv_err_o));

    p_inv_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_err_o && !clr_i) |=> inv_err_o);

    p_no_err_unlocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked_o && !clr_i) |=> $stable(err_cnt_o));
endmodule

// File: tb/test_pat_lfsr_checker.sv
module test_pat_lfsr_checker;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 5;
    localparam int NV = 11;

    // Stimulus groups: sample count, corruption kind, cumulative expectations.
    // Kinds: 0 clean, 1 A lanes bit0 flipped, 2 AQ bit5 only,
    //        3 B lanes bit11 flipped, 4 alternate kind 1 and clean.
    localparam int    T_N   [NV] = '{19, 1, 10, 1, 7, 16, 1, 1, 3, 1, 44};
    localparam int    T_K   [NV] = '{ 0, 0,  0, 1, 1,  0, 0, 2, 0, 3,  4};
    localparam int    T_L   [NV] = '{ 0, 1,  1, 1, 0,  0, 1, 1, 1, 1,  1};
    localparam int    T_E   [NV] = '{ 0, 0,  0, 1, 8,  8, 8, 9, 9, 10, 31};
    localparam int    T_C   [NV] = '{ 0, 0, 10, 11, 18, 18, 18, 19, 22, 23, 31};
    localparam int    T_I   [NV] = '{ 0, 0,  0, 0, 0,  0, 0, 1, 1, 1,  1};
    localparam string T_R   [NV] = '{"R3", "R3", "R1 R2 R7", "R1 R5", "R4",
                                     "R3 R4", "R3", "R10", "R10", "R2 R5", "R6 R7"};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          vld = 1'b0;
    logic [11:0]   ai = '0, aq = '0, bi = '0, bq = '0;
    logic          locked;
    logic [CW-1:0] err_cnt, chk_cnt;
    logic          inv_err;

    logic [14:0]   ga, gb;
    int            checks = 0;
    int            failures = 0;
    bit            done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pat_lfsr_checker #(.CNT_W(CW)) i_pat_lfsr_checker (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .vld_i(vld),
        .ai_i(ai), .aq_i(aq), .bi_i(bi), .bq_i(bq),
        .locked_o(locked), .err_cnt_o(err_cnt), .chk_cnt_o(chk_cnt),
        .inv_err_o(inv_err)
    );

    function automatic logic [14:0] nxt(input logic [14:0] s);
        return {s[13:0], s[14] ^ s[13]};
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input int l, input int e, input int c, input int i);
        check(req, "locked", int'(locked), l);
        check(req, "err_cnt", int'(err_cnt), e);
        check(req, "chk_cnt", int'(chk_cnt), c);
        check(req, "inv_err", int'(inv_err), i);
    endtask

    // One generated sample per call; corruption applied on the lanes only.
    task automatic send(input int kind);
        logic [11:0] wa, wb;
        wa = ga[11:0];
        wb = gb[14:3];
        @(negedge clk);
        ai = wa; aq = ~wa; bi = wb; bq = ~wb;
        case (kind)
            1: begin ai = ai ^ 12'h001; aq = aq ^ 12'h001; end
            2: aq = aq ^ 12'h020;
            3: begin bi = bi ^ 12'h800; bq = bq ^ 12'h800; end
            default: ;
        endcase
        vld = 1'b1;
        ga = nxt(ga);
        gb = nxt(gb);
    endtask

    task automatic send_raw(input logic [11:0] x, input logic v);
        @(negedge clk);
        ai = x; aq = x; bi = ~x; bq = x;
        vld = v;
    endtask

    task automatic settle;
        @(negedge clk);
        vld = 1'b0;
    endtask

    initial begin
        ga = 15'b100000000000001;
        gb = 15'b100000000000001;
        for (int k = 0; k < 500; k++) gb = nxt(gb);   // independent B phase

        repeat (3) @(negedge clk);
        // R11: reset state
        check_all("R11", 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R11", 0, 0, 0, 0);

        // Table walk
        for (int t = 0; t < NV; t++) begin
            for (int n = 0; n < T_N[t]; n++) begin
                if (T_K[t] == 4) send((n % 2 == 0) ? 1 : 0);
                else             send(T_K[t]);
            end
            settle();
            check_all(T_R[t], T_L[t], T_E[t], T_C[t], T_I[t]);
        end

        // R9: clear
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        check_all("R9", 0, 0, 0, 0);

        // R5 R10: garbage while unlocked counts nothing, sets no flag
        for (int n = 0; n < 10; n++) send_raw(12'(n * 37 + 5), 1'b1);
        settle();
        check_all("R5 R10", 0, 0, 0, 0);

        // R3 R8: arbitrary phase, invalid garbage cycles interleaved
        for (int k = 0; k < 1234; k++) ga = nxt(ga);
        for (int k = 0; k < 77; k++)   gb = nxt(gb);
        for (int n = 0; n < 20; n++) begin
            send(0);
            send_raw(12'hA5A, 1'b0);
        end
        settle();
        check("R3", "locked arbitrary phase", int'(locked), 1);
        check("R5", "err_cnt after relock", int'(err_cnt), 0);

        for (int n = 0; n < 6; n++) begin
            send(0);
            send_raw(12'h3C3, 1'b0);
            send_raw(12'h0F0, 1'b0);
        end
        settle();
        check("R8", "locked across gaps", int'(locked), 1);
        check("R8", "err_cnt across gaps", int'(err_cnt), 0);
        check("R8 R10", "inv_err across gaps", int'(inv_err), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule